// File: doc/BRIEF.md
# Random Number Generator Control with Seed-Fault Recovery

This block is the register-mapped front end of a random number generator. A small bus with separate write and read strobes, an address and 32-bit data reaches a control word, a status word, a data port and two configuration words for the noise source and its health tests. Behind the bus, a 32-bit linear feedback shift register stands in for the entropy source. It advances on a generator clock made by dividing the input clock by a power of two, and it fills a four-word output queue. A non-empty queue raises the data-ready flag.

A fault input models a broken noise source. A fault raises two flags, a sticky interrupt flag and a live status flag, and it stops and empties the queue. There are two ways back to normal operation. Software can pulse the conditional-reset control bit high and then low, which runs a reset sequence of fixed length; hardware then clears the bit. If the fault has gone away on its own, hardware runs the same sequence without help and leaves only the interrupt flag for software to clear. The configuration fields can only be written while conditional reset is held high.

Top module: `rng_ctrl_top`

## Requirements
- R1: After reset the control, status, noise-control and health-test registers all read 0, and the read data output is 0.
- R2: The control bits at mask 0x03FF_FF20 (clock-error-detect disable bit 5, configuration bits 25:8 including the divider exponent 19:16), the noise-control register (bits 17:0) and the health-test register change on a write only while control bit 30 reads 1 and no reset sequence is running. Enable (bit 2) can always be written.
- R3: While enabled, each generator tick pushes the next state of a Galois LFSR into a 4-word FIFO in order. The LFSR shifts right and XORs 0x8020_0003 when the bit shifted out is 1, and it starts from seed 1. Status bit 0 reads 1 when the FIFO holds a word.
- R4: A read at offset 0x08 returns the oldest word and removes it. A read from an empty FIFO returns 0, and 0 is never pushed as a valid word.
- R5: A generator tick occurs once every 2^E input clocks, where E is control bits 19:16.
- R6: A fault while enabled sets status bit 6 (seed interrupt) and bit 2 (seed current status), empties the FIFO and stops generation.
- R7: Writing control bit 30 as 0 while it reads 1 starts a sequence of 16 generator ticks. During the sequence bit 30 keeps reading 1 and the FIFO stays empty. At its end hardware clears bit 30 and status bit 6, and it also clears status bit 2 if the fault has gone.
- R8: When status bit 2 is set, the fault has gone, bit 30 is 0 and no sequence is running, hardware runs the 16-tick sequence by itself. It then clears status bit 2 and leaves status bit 6 set.
- R9: A status write clears bit 6 (and bit 5) where the written bit is 0. Writing 1 has no effect.
- R10: Writing 0 to the control register clears enable, so no more words are pushed. The protected fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_re |
| src_fault | input | 1 | Noise-source fault injection |

## Verification
Read data is registered, so the bench drives each read on a falling edge and samples bus_rdata on the next falling edge, one edge after the strobe. A write acts on the rising edge that follows it, so flags and readback are checked on the very next access. The fault input passes through one register before it sets the status flags, so the bench waits several cycles before it reads status. The reset sequence takes 16 ticks, which is 16 clocks at exponent 0 and about 256 clocks at exponent 4. The bench therefore reads the conditional-reset bit at points well inside and well past that window instead of on an exact edge, and it does the same for queue refill after enable.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int REG_W = 32;

  localparam logic [4:0] OFF_CTRL  = 5'h00;
  localparam logic [4:0] OFF_STAT  = 5'h04;
  localparam logic [4:0] OFF_DATA  = 5'h08;
  localparam logic [4:0] OFF_NOISE = 5'h0C;
  localparam logic [4:0] OFF_HTEST = 5'h10;

  localparam int CB_EN      = 2;
  localparam int CB_DIV_LO  = 16;
  localparam int CB_CONDRST = 30;

  localparam int SB_DRDY    = 0;
  localparam int SB_CSF     = 2;
  localparam int SB_SEEDINT = 6;

  localparam logic [REG_W-1:0] CTRL_PROT_MASK = 32'h03FF_FF20;
endpackage

// File: rtl/rng_clkdiv.sv
module rng_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] exp_sel,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    mask = ~({CNT_W{1'b1}} << exp_sel);
    tick = run && ((cnt_q & mask) == mask);
  end
endmodule

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] word_o
);
  logic [W-1:0] state_q;

  always_comb word_o = (state_q >> 1) ^ (state_q[0] ? MASK : '0);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= word_o;
  end
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CW'(DEPTH));
    do_push = push && !full && !flush;
    do_pop  = pop && !empty && !flush;
    dout    = mem[rd_ptr];
    count   = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
  import rng_pkg::*;
#(
  parameter int          ADDR_W       = 5,
  parameter int          FIFO_DEPTH   = 4,
  parameter int          RST_TICKS    = 16,
  parameter int          DIV_W        = 4,
  parameter int          NOISE_W      = 18,
  parameter bit          AUTO_RECOVER = 1'b1,
  parameter logic [31:0] LFSR_MASK    = 32'h8020_0003,
  parameter logic [31:0] LFSR_SEED    = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              src_fault
);
  localparam int SEQ_W  = $clog2(RST_TICKS + 1);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic [REG_W-1:0]   cr_q;
  logic               condrst_q, busy_q, seq_sw_q, seis_q, csf_q, fault_q;
  logic [NOISE_W-1:0] noise_q;
  logic [REG_W-1:0]   htest_q;
  logic [SEQ_W-1:0]   seq_cnt;

  logic              en, cfg_open, tick;
  logic              wr_cr, wr_sr, wr_ns, wr_ht, rd_dr;
  logic              start_sw, start_auto, fault_hit, seq_done, flush;
  logic              push, pop, fifo_empty, fifo_full;
  logic [31:0]       push_word, fifo_dout;
  logic [FCNT_W-1:0] fifo_count;

  always_comb begin
    en         = cr_q[CB_EN];
    cfg_open   = condrst_q && !busy_q;
    wr_cr      = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    wr_sr      = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
    wr_ns      = bus_we && (bus_addr == ADDR_W'(OFF_NOISE));
    wr_ht      = bus_we && (bus_addr == ADDR_W'(OFF_HTEST));
    rd_dr      = bus_re && (bus_addr == ADDR_W'(OFF_DATA));
    start_sw   = wr_cr && cfg_open && !bus_wdata[CB_CONDRST];
    start_auto = AUTO_RECOVER && csf_q && !fault_q && !busy_q && !condrst_q && !start_sw;
    fault_hit  = fault_q && en && !busy_q;
    seq_done   = busy_q && tick && (seq_cnt == SEQ_W'(RST_TICKS - 1));
    flush      = busy_q || fault_hit || start_sw || start_auto;
    push       = tick && en && !busy_q && !csf_q && !fault_hit && !fifo_full && !flush;
    pop        = rd_dr && !fifo_empty;
  end

  rng_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(en || busy_q),
    .exp_sel(cr_q[CB_DIV_LO +: DIV_W]), .tick(tick)
  );

  rng_lfsr #(.W(32), .MASK(LFSR_MASK), .SEED(LFSR_SEED)) u_src (
    .clk(clk), .rst(rst), .adv(push), .word_o(push_word)
  );

  rng_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .din(push_word),
    .pop(pop), .dout(fifo_dout), .count(fifo_count),
    .empty(fifo_empty), .full(fifo_full)
  );

  // Control register, configuration and recovery sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q      <= '0;
      condrst_q <= 1'b0;
      noise_q   <= '0;
      htest_q   <= '0;
      busy_q    <= 1'b0;
      seq_sw_q  <= 1'b0;
      seq_cnt   <= '0;
      seis_q    <= 1'b0;
      csf_q     <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      fault_q <= src_fault;
      if (wr_cr) begin
        if (cfg_open) cr_q <= (cr_q & ~CTRL_PROT_MASK) | (bus_wdata & CTRL_PROT_MASK);
        cr_q[CB_EN] <= bus_wdata[CB_EN];
        if (!busy_q && !start_sw) condrst_q <= bus_wdata[CB_CONDRST];
      end
      if (wr_ns && cfg_open) noise_q <= bus_wdata[NOISE_W-1:0];
      if (wr_ht && cfg_open) htest_q <= bus_wdata;

      if (start_sw || start_auto) begin
        busy_q   <= 1'b1;
        seq_sw_q <= start_sw;
        seq_cnt  <= '0;
      end else if (busy_q && tick) begin
        if (seq_done) busy_q <= 1'b0;
        else          seq_cnt <= seq_cnt + 1'b1;
      end

      if (wr_sr && !bus_wdata[SB_SEEDINT]) seis_q <= 1'b0;
      if (seq_done && seq_sw_q) begin
        condrst_q <= 1'b0;
        seis_q    <= 1'b0;
      end
      if (seq_done && !fault_q) csf_q <= 1'b0;
      if (fault_hit) begin
        seis_q <= 1'b1;
        csf_q  <= 1'b1;
      end
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      unique case (bus_addr)
        ADDR_W'(OFF_CTRL):  bus_rdata <= cr_q | (32'(condrst_q) << CB_CONDRST);
        ADDR_W'(OFF_STAT):  bus_rdata <= (32'(seis_q) << SB_SEEDINT) |
                                         (32'(csf_q) << SB_CSF) |
                                         (32'(!fifo_empty) << SB_DRDY);
        ADDR_W'(OFF_DATA):  bus_rdata <= fifo_empty ? '0 : fifo_dout;
        ADDR_W'(OFF_NOISE): bus_rdata <= 32'(noise_q);
        ADDR_W'(OFF_HTEST): bus_rdata <= htest_q;
        default:            bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rng_ctrl_sva.sv
module rng_ctrl_sva #(
  parameter int ADDR_W     = 5,
  parameter int FIFO_DEPTH = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_re,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_rdata,
  input logic                          push,
  input logic [31:0]                   push_word,
  input logic                          fifo_empty,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  input logic                          busy_q,
  input logic                          seq_sw_q,
  input logic                          csf_q,
  input logic                          condrst_q
);
  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  p_no_zero_word_r4: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_word != 32'h0));

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(8) && fifo_empty) |=> (bus_rdata == 32'h0));

  p_halt_on_fault_r6: assert property (@(posedge clk) disable iff (rst)
    csf_q |-> !push);

  p_empty_in_seq_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> fifo_empty);

  p_condrst_self_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_q) && $past(seq_sw_q)) |-> !condrst_q);
endmodule

bind rng_ctrl_top rng_ctrl_sva #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_sva (
  .clk(clk), .rst(rst), .bus_re(bus_re), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .push(push), .push_word(push_word), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
  .busy_q(busy_q), .seq_sw_q(seq_sw_q), .csf_q(csf_q), .condrst_q(condrst_q)
);

// File: tb/rng_ctrl_top_tb.sv
module rng_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0, src_fault = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_ctrl_top u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_fault(src_fault)
  );

  // {req[3:0], wr, addr[7:0], data[31:0], expected[31:0]}
  // R1: reset values; R2: write protection; R7: sequence busy readback
  localparam logic [76:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 8'h00, 32'h0, 32'h0},
    {4'd1, 1'b0, 8'h04, 32'h0, 32'h0},
    {4'd1, 1'b0, 8'h0C, 32'h0, 32'h0},
    {4'd1, 1'b0, 8'h10, 32'h0, 32'h0},
    {4'd2, 1'b1, 8'h00, 32'h0000_0F20, 32'h0},
    {4'd2, 1'b0, 8'h00, 32'h0, 32'h0},
    {4'd2, 1'b1, 8'h0C, 32'h0003_FFFF, 32'h0},
    {4'd2, 1'b0, 8'h0C, 32'h0, 32'h0},
    {4'd2, 1'b1, 8'h00, 32'h4000_0000, 32'h0},
    {4'd2, 1'b1, 8'h00, 32'h4000_0F20, 32'h0},
    {4'd2, 1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
    {4'd2, 1'b1, 8'h10, 32'h1234_5678, 32'h0},
    {4'd2, 1'b0, 8'h0C, 32'h0, 32'h0003_FFFF},
    {4'd2, 1'b0, 8'h10, 32'h0, 32'h1234_5678},
    {4'd2, 1'b0, 8'h00, 32'h0, 32'h4000_0F20},
    {4'd7, 1'b1, 8'h00, 32'h0000_0F24, 32'h0},
    {4'd7, 1'b0, 8'h00, 32'h0, 32'h4000_0F24}
  };

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, model;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", bus_rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][72]) wr(VEC[i][68:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][68:64], v);
        check($sformatf("R%0d vector %0d", VEC[i][76:73], i), v, VEC[i][31:0]);
      end
    end

    // R7: sequence finishes, bit 30 self-clears; R3: words arrive in LFSR order
    idle(40);
    rd(5'h00, v); check("R7 condrst self-cleared", v, 32'h0000_0F24);
    rd(5'h04, v); check("R3 data ready", v, 32'h1);
    model = 32'h1;
    for (int k = 0; k < 4; k++) begin
      model = lfsr_step(model);
      rd(5'h08, v); check($sformatf("R3 word %0d", k), v, model);
    end

    // R10: disable, R4: drain then empty read returns 0
    wr(5'h00, 32'h0);
    idle(3);
    for (int k = 0; k < 4; k++) begin
      rd(5'h08, v); check("R4 drained word nonzero", 32'(v != 0), 32'h1);
    end
    rd(5'h08, v); check("R4 empty read zero", v, 32'h0);
    rd(5'h04, v); check("R10 no refill when disabled", v, 32'h0);
    rd(5'h00, v); check("R10 enable cleared, fields kept", v, 32'h0000_0F20);

    wr(5'h00, 32'h4);
    idle(10);
    rd(5'h04, v); check("R3 ready after enable", v, 32'h1);

    // R6: fault
    src_fault = 1'b1;
    idle(5);
    rd(5'h04, v); check("R6 flags set, queue empty", v, 32'h44);
    rd(5'h08, v); check("R6 data zero on fault", v, 32'h0);

    // R8: automatic recovery
    src_fault = 1'b0;
    idle(40);
    rd(5'h04, v); check("R8 auto recovery keeps interrupt", v, 32'h41);

    // R9: write-one no effect, write-zero clears
    wr(5'h04, 32'h7F);
    rd(5'h04, v); check("R9 write one ignored", v, 32'h41);
    wr(5'h04, 32'h0);
    rd(5'h04, v); check("R9 write zero clears", v, 32'h01);

    // R7: software conditional reset while fault present
    src_fault = 1'b1;
    idle(5);
    wr(5'h00, 32'h4000_0004);
    wr(5'h00, 32'h0000_0004);
    src_fault = 1'b0;
    rd(5'h00, v); check("R7 busy reads bit 30", v, 32'h4000_0004);
    idle(40);
    rd(5'h04, v); check("R7 flags cleared after sequence", v, 32'h01);
    rd(5'h00, v); check("R7 condrst cleared", v, 32'h0000_0004);

    // R5: divider exponent 4 stretches the 16-tick sequence to about 256 clocks
    idle(10);
    wr(5'h00, 32'h4000_0004);
    wr(5'h00, 32'h0004_0004);
    rd(5'h04, v); check("R7 queue flushed in sequence", v, 32'h0);
    idle(100);
    rd(5'h00, v); check("R5 slow sequence still running", v, 32'h4004_0004);
    idle(300);
    rd(5'h00, v); check("R5 slow sequence done", v, 32'h0004_0004);
    idle(40);
    rd(5'h04, v); check("R5 data at divided rate", v, 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule